// File: doc/BRIEF.md
# Staged Two-Phase Memory Write Controller

This block sits between a command parser and a memory write port. It never writes a payload when the payload arrives. A write command places one or two data bytes in a staging register, and the block asks a reply formatter to echo them back to the host. The bytes reach memory only after a separate destination command names the target address and, for some commands, the address space. Serial framing and checksum checks happen upstream. The memory arrays are outside the block.

Commands arrive as already-validated frames, each holding an identifier byte and two operand bytes, on a valid/ready stream. The block accepts at most one command at a time. While it owns a pending reply or is driving memory write cycles, it holds `cmd_ready` low, so upstream must keep a frame and its fields steady until `cmd_ready` rises. Replies leave on a second valid/ready stream. Once `rsp_valid` rises, the reply holds still until the formatter takes it with `rsp_ready`. The memory port has no flow control: each cycle with `wr_en` high is one byte written.

Top module: `staged_commit_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0 and `wr_en` is 0, and nothing is staged.
- R2: A command with identifier 0x10 whose second operand is the bitwise inverse of the first stages the first operand as a byte. In the cycle after acceptance it raises a reply with identifier 0xA0, `rsp_d0` set to the byte and `rsp_d1` set to its inverse, and it makes no memory write.
- R3: A 0x10 command whose second operand is not the inverse of the first produces the reject reply (identifier 0xFF, `rsp_d0` 0x00, `rsp_d1` 0xFF) and leaves the staged contents as they were.
- R4: A command with identifier 0x11 stages both operands as a word and raises a reply with identifier 0xA1 carrying the first operand in `rsp_d0` and the second in `rsp_d1`, with no memory write.
- R5: A write command that arrives while data is already staged replaces that data, including its byte or word size. Only the most recent payload is ever committed.
- R6: Identifier 0x20, with a byte staged and both operands equal, produces one write cycle. That cycle begins in the cycle after acceptance and carries address zero-extended from the operand, RAM space (`wr_rom`=0) and byte size (`wr_word`=0). If the two operands differ, the command is rejected.
- R7: Identifiers 0x21 and 0x22, with a byte staged, produce one byte write cycle to the address formed from the first operand (high byte) and the second operand (low byte). Space is RAM for 0x21 and ROM emulation (`wr_rom`=1) for 0x22.
- R8: Identifier 0x23, with a word staged, produces two consecutive write cycles in ROM space with `wr_word`=1. The first writes the first staged byte at the given address. The second writes the second staged byte at that address plus one, wrapping at the top of the address range.
- R9: A successful commit empties the staging register, so a repeated destination command is rejected.
- R10: A destination command (0x20 to 0x23) that arrives with nothing staged is rejected and makes no memory write.
- R11: A byte destination (0x20 to 0x22) with a word staged, or 0x23 with a byte staged, is rejected and keeps the staged data for a later destination of the correct size.
- R12: Any identifier other than 0x10, 0x11 and 0x20 to 0x23 is rejected.
- R13: A raised reply keeps `rsp_valid` and its fields steady until `rsp_ready` is seen. `cmd_ready` stays low while a reply is pending or a write cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command frame present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_id | input | 8 | Command identifier |
| cmd_op0 | input | DW | First operand byte |
| cmd_op1 | input | DW | Second operand byte |
| rsp_valid | output | 1 | Reply request present |
| rsp_ready | input | 1 | Reply formatter takes the request |
| rsp_id | output | 8 | Reply identifier (echo or reject) |
| rsp_d0 | output | DW | First reply payload byte |
| rsp_d1 | output | DW | Second reply payload byte |
| wr_en | output | 1 | Memory write strobe, one byte per cycle |
| wr_addr | output | 2*DW | Write address |
| wr_data | output | DW | Write data byte |
| wr_rom | output | 1 | 1 selects ROM-emulation space, 0 selects RAM |
| wr_word | output | 1 | 1 when the cycle belongs to a two-byte commit |

## Verification
The assertions assume that upstream holds a frame's identifier and operands steady while `cmd_valid` waits for `cmd_ready`. They also assume that the operands a command carries describe what the host intended, because the block cannot tell a well-formed but unwanted frame from a good one. The bench raises `cmd_valid` only at a falling edge where `cmd_ready` is already high, and it drops the request one cycle later. Every accepted frame therefore belongs to exactly one command. The sweeps cover every byte value through the byte echo and commit path, every 8-bit short address, a set of word addresses that includes the wrap at the top of the range, and every identifier outside the command set.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int ID_W = 8;

  localparam logic [ID_W-1:0] ID_WR_BYTE  = 8'h10;
  localparam logic [ID_W-1:0] ID_WR_WORD  = 8'h11;
  localparam logic [ID_W-1:0] ID_DST_SHRT = 8'h20;
  localparam logic [ID_W-1:0] ID_DST_RAM  = 8'h21;
  localparam logic [ID_W-1:0] ID_DST_ROM  = 8'h22;
  localparam logic [ID_W-1:0] ID_DST_ROMW = 8'h23;
  localparam logic [ID_W-1:0] ID_ECHO_B   = 8'hA0;
  localparam logic [ID_W-1:0] ID_ECHO_W   = 8'hA1;
  localparam logic [ID_W-1:0] ID_REJECT   = 8'hFF;

  typedef enum logic [2:0] {
    ACT_REJECT,
    ACT_STAGE_B,
    ACT_STAGE_W,
    ACT_COMMIT_B,
    ACT_COMMIT_W
  } act_e;
endpackage

// File: rtl/stw_cmd_decode.sv
module stw_cmd_decode
  import stw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [ID_W-1:0] id,
  input  logic [DW-1:0]   op0,
  input  logic [DW-1:0]   op1,
  input  logic            stg_valid,
  input  logic            stg_word,
  output act_e            act,
  output logic [2*DW-1:0] addr,
  output logic            rom
);
  logic byte_ok;
  logic word_ok;

  assign byte_ok = stg_valid && !stg_word;
  assign word_ok = stg_valid && stg_word;

  always_comb begin
    act  = ACT_REJECT;
    addr = {op0, op1};
    rom  = 1'b0;
    case (id)
      ID_WR_BYTE:  if (op1 == ~op0) act = ACT_STAGE_B;
      ID_WR_WORD:  act = ACT_STAGE_W;
      ID_DST_SHRT: begin
        addr = {{DW{1'b0}}, op0};
        if (op0 == op1 && byte_ok) act = ACT_COMMIT_B;
      end
      ID_DST_RAM:  if (byte_ok) act = ACT_COMMIT_B;
      ID_DST_ROM: begin
        rom = 1'b1;
        if (byte_ok) act = ACT_COMMIT_B;
      end
      ID_DST_ROMW: begin
        rom = 1'b1;
        if (word_ok) act = ACT_COMMIT_W;
      end
      default: act = ACT_REJECT;
    endcase
  end
endmodule

// File: rtl/stw_stage_buf.sv
module stw_stage_buf
  import stw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  act_e          act,
  input  logic [DW-1:0] op0,
  input  logic [DW-1:0] op1,
  output logic          stg_valid,
  output logic          stg_word,
  output logic [DW-1:0] stg_d0,
  output logic [DW-1:0] stg_d1
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_word  <= 1'b0;
      stg_d0    <= '0;
      stg_d1    <= '0;
    end else if (fire) begin
      case (act)
        ACT_STAGE_B: begin
          stg_valid <= 1'b1;
          stg_word  <= 1'b0;
          stg_d0    <= op0;
          stg_d1    <= op1;
        end
        ACT_STAGE_W: begin
          stg_valid <= 1'b1;
          stg_word  <= 1'b1;
          stg_d0    <= op0;
          stg_d1    <= op1;
        end
        ACT_COMMIT_B, ACT_COMMIT_W: stg_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_REJECT) |=> $stable(stg_valid) && $stable(stg_d0) && $stable(stg_d1)); // R3
endmodule

// File: rtl/stw_commit_seq.sv
module stw_commit_seq
  import stw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  act_e            act,
  input  logic [2*DW-1:0] addr,
  input  logic            rom,
  input  logic [DW-1:0]   op0,
  input  logic [DW-1:0]   op1,
  input  logic [DW-1:0]   stg_d0,
  input  logic [DW-1:0]   stg_d1,
  output logic            cmd_ready,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [ID_W-1:0] rsp_id,
  output logic [DW-1:0]   rsp_d0,
  output logic [DW-1:0]   rsp_d1,
  output logic            wr_en,
  output logic [2*DW-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            wr_rom,
  output logic            wr_word
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ADDR_STEP = {{(AW-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_RSP, S_WR_LO, S_WR_HI} st_e;

  st_e             state;
  logic [AW-1:0]   addr_q;
  logic            rom_q;
  logic            word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      rom_q  <= 1'b0;
      word_q <= 1'b0;
      rsp_id <= '0;
      rsp_d0 <= '0;
      rsp_d1 <= '0;
    end else begin
      case (state)
        S_IDLE: if (fire) begin
          case (act)
            ACT_STAGE_B: begin
              rsp_id <= ID_ECHO_B;
              rsp_d0 <= op0;
              rsp_d1 <= op1;
              state  <= S_RSP;
            end
            ACT_STAGE_W: begin
              rsp_id <= ID_ECHO_W;
              rsp_d0 <= op0;
              rsp_d1 <= op1;
              state  <= S_RSP;
            end
            ACT_COMMIT_B, ACT_COMMIT_W: begin
              addr_q <= addr;
              rom_q  <= rom;
              word_q <= (act == ACT_COMMIT_W);
              state  <= S_WR_LO;
            end
            default: begin
              rsp_id <= ID_REJECT;
              rsp_d0 <= '0;
              rsp_d1 <= '1;
              state  <= S_RSP;
            end
          endcase
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        S_WR_LO: begin
          if (word_q) begin
            addr_q <= addr_q + ADDR_STEP;
            state  <= S_WR_HI;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RSP);
  assign wr_en     = (state == S_WR_LO) || (state == S_WR_HI);
  assign wr_addr   = addr_q;
  assign wr_data   = (state == S_WR_HI) ? stg_d1 : stg_d0;
  assign wr_rom    = rom_q;
  assign wr_word   = word_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_id) && $stable(rsp_d0) && $stable(rsp_d1)); // R13
  AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready); // R13
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_LO && word_q) |=> wr_en && wr_word && wr_addr == $past(wr_addr) + ADDR_STEP); // R8
  AST_COMMIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (act == ACT_COMMIT_B || act == ACT_COMMIT_W)) |=> wr_en && !rsp_valid); // R6
endmodule

// File: rtl/staged_commit_ctrl.sv
module staged_commit_ctrl
  import stw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [7:0]      cmd_id,
  input  logic [DW-1:0]   cmd_op0,
  input  logic [DW-1:0]   cmd_op1,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [7:0]      rsp_id,
  output logic [DW-1:0]   rsp_d0,
  output logic [DW-1:0]   rsp_d1,
  output logic            wr_en,
  output logic [2*DW-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            wr_rom,
  output logic            wr_word
);
  localparam int AW = 2 * DW;

  act_e          act;
  logic [AW-1:0] dec_addr;
  logic          dec_rom;
  logic          fire;
  logic          stg_valid;
  logic          stg_word;
  logic [DW-1:0] stg_d0;
  logic [DW-1:0] stg_d1;
  logic          is_dest;

  assign fire    = cmd_valid && cmd_ready;
  assign is_dest = (cmd_id == ID_DST_SHRT) || (cmd_id == ID_DST_RAM) ||
                   (cmd_id == ID_DST_ROM)  || (cmd_id == ID_DST_ROMW);

  stw_cmd_decode #(.DW(DW)) u_dec (
    .id        (cmd_id),
    .op0       (cmd_op0),
    .op1       (cmd_op1),
    .stg_valid (stg_valid),
    .stg_word  (stg_word),
    .act       (act),
    .addr      (dec_addr),
    .rom       (dec_rom)
  );

  stw_stage_buf #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .act       (act),
    .op0       (cmd_op0),
    .op1       (cmd_op1),
    .stg_valid (stg_valid),
    .stg_word  (stg_word),
    .stg_d0    (stg_d0),
    .stg_d1    (stg_d1)
  );

  stw_commit_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .act       (act),
    .addr      (dec_addr),
    .rom       (dec_rom),
    .op0       (cmd_op0),
    .op1       (cmd_op1),
    .stg_d0    (stg_d0),
    .stg_d1    (stg_d1),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_d0    (rsp_d0),
    .rsp_d1    (rsp_d1),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_rom    (wr_rom),
    .wr_word   (wr_word)
  );

  AST_EMPTY_DEST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_dest && !stg_valid) |=> !wr_en && rsp_valid && rsp_id == ID_REJECT); // R10
  AST_WORD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_id == ID_WR_WORD) |=> !wr_en && rsp_valid && rsp_id == ID_ECHO_W); // R4
  AST_DRAINED_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !stg_valid); // R9
  AST_SIZE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_id == ID_DST_ROMW && stg_valid && !stg_word) |=> rsp_valid && rsp_id == ID_REJECT && stg_valid); // R11
endmodule

// File: tb/sim_staged_commit_ctrl.sv
module sim_staged_commit_ctrl;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_id = '0;
  logic [DW-1:0] cmd_op0 = '0;
  logic [DW-1:0] cmd_op1 = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [7:0]    rsp_id;
  logic [DW-1:0] rsp_d0;
  logic [DW-1:0] rsp_d1;
  logic          wr_en;
  logic [15:0]   wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_rom;
  logic          wr_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  staged_commit_ctrl #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
    .cmd_op0(cmd_op0), .cmd_op1(cmd_op1),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_d0(rsp_d0), .rsp_d1(rsp_d1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_rom(wr_rom), .wr_word(wr_word)
  );

  task automatic chk(input bit ok, input string rq, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] id, input logic [7:0] o0, input logic [7:0] o1);
    chk(cmd_ready == 1'b1, "R13", {39'd0, cmd_ready}, 40'd1);
    cmd_id = id;
    cmd_op0 = o0;
    cmd_op1 = o1;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take_rsp(input string rq, input logic [7:0] id, input logic [7:0] d0,
                          input logic [7:0] d1, input bit stall);
    logic [24:0] got;
    got = {rsp_valid, rsp_id, rsp_d0, rsp_d1};
    chk(got == {1'b1, id, d0, d1} && !wr_en, rq, {14'd0, wr_en, got}, {15'd0, 1'b1, id, d0, d1});
    if (stall) begin
      @(negedge clk);
      got = {rsp_valid, rsp_id, rsp_d0, rsp_d1};
      chk(got == {1'b1, id, d0, d1} && !cmd_ready, "R13", {14'd0, cmd_ready, got},
          {15'd0, 1'b1, id, d0, d1});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready && !wr_en, rq, {37'd0, rsp_valid, cmd_ready, wr_en}, 40'b010);
  endtask

  task automatic take_wr(input string rq, input logic [15:0] a, input logic [7:0] d,
                         input bit rom, input bit word);
    logic [26:0] got;
    got = {wr_en, wr_addr, wr_data, wr_rom, wr_word};
    chk(got == {1'b1, a, d, rom, word} && !rsp_valid, rq, {13'd0, got},
        {13'd0, 1'b1, a, d, rom, word});
    @(negedge clk);
  endtask

  task automatic idle_chk(input string rq);
    chk(!wr_en && !rsp_valid && cmd_ready, rq, {37'd0, wr_en, rsp_valid, cmd_ready}, 40'b001);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R13 actual=%h expected=%h", 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [7:0]  w0;
    logic [7:0]  w1;
    logic [15:0] a;
    repeat (3) @(negedge clk);
    idle_chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1");
    // R1: nothing staged after reset
    send(8'h22, 8'h12, 8'h34);
    take_rsp("R1", 8'hFF, 8'h00, 8'hFF, 1'b0);

    // R2, R7, R9: every byte value through echo and commit
    for (int d = 0; d < 256; d++) begin
      v = d[7:0];
      send(8'h10, v, ~v);
      take_rsp("R2", 8'hA0, v, ~v, (d % 37) == 0);
      a = {v, v ^ 8'h5A};
      send((d % 2) ? 8'h22 : 8'h21, a[15:8], a[7:0]);
      take_wr("R7", a, v, (d % 2) == 1, 1'b0);
      idle_chk("R9");
      if ((d % 16) == 0) begin
        send(8'h21, a[15:8], a[7:0]);
        take_rsp("R9", 8'hFF, 8'h00, 8'hFF, 1'b0);
      end
    end

    // R6: every short address, with occasional copy mismatch
    for (int s = 0; s < 256; s++) begin
      v = 8'(s * 3 + 1);
      send(8'h10, v, ~v);
      take_rsp("R2", 8'hA0, v, ~v, 1'b0);
      if ((s % 32) == 7) begin
        send(8'h20, s[7:0], s[7:0] ^ 8'h01);
        take_rsp("R6", 8'hFF, 8'h00, 8'hFF, 1'b0);
      end
      send(8'h20, s[7:0], s[7:0]);
      take_wr("R6", {8'h00, s[7:0]}, v, 1'b0, 1'b0);
      idle_chk("R6");
    end

    // R3: broken inverse leaves the staged byte alone
    for (int k = 0; k < 8; k++) begin
      send(8'h10, 8'h3C, 8'hC3);
      take_rsp("R2", 8'hA0, 8'h3C, 8'hC3, 1'b0);
      v = 8'(k * 29 + 5);
      send(8'h10, v, (~v) ^ (8'h01 << k));
      take_rsp("R3", 8'hFF, 8'h00, 8'hFF, 1'b0);
      send(8'h21, 8'h40, 8'(k));
      take_wr("R3", {8'h40, 8'(k)}, 8'h3C, 1'b0, 1'b0);
    end

    // R4, R8: word staging and two-cycle commits, top address wraps
    for (int i = 0; i < 64; i++) begin
      w0 = 8'(i * 5 + 2);
      w1 = 8'(~(i * 11));
      a = (i == 63) ? 16'hFFFF : 16'(i * 1031 + 16'hFFC0);
      send(8'h11, w0, w1);
      take_rsp("R4", 8'hA1, w0, w1, (i % 20) == 3);
      send(8'h23, a[15:8], a[7:0]);
      take_wr("R8", a, w0, 1'b1, 1'b1);
      take_wr("R8", a + 16'd1, w1, 1'b1, 1'b1);
      idle_chk("R8");
    end

    // R5: later payloads replace earlier ones
    send(8'h10, 8'h11, 8'hEE);
    take_rsp("R5", 8'hA0, 8'h11, 8'hEE, 1'b0);
    send(8'h11, 8'hAB, 8'hCD);
    take_rsp("R5", 8'hA1, 8'hAB, 8'hCD, 1'b0);
    send(8'h10, 8'h77, 8'h88);
    take_rsp("R5", 8'hA0, 8'h77, 8'h88, 1'b0);
    send(8'h23, 8'h10, 8'h00);
    take_rsp("R5", 8'hFF, 8'h00, 8'hFF, 1'b0);
    send(8'h21, 8'h12, 8'h34);
    take_wr("R5", 16'h1234, 8'h77, 1'b0, 1'b0);

    // R11: size mismatch rejected, staged data kept
    send(8'h11, 8'h5A, 8'hA5);
    take_rsp("R4", 8'hA1, 8'h5A, 8'hA5, 1'b0);
    send(8'h20, 8'h09, 8'h09);
    take_rsp("R11", 8'hFF, 8'h00, 8'hFF, 1'b0);
    send(8'h21, 8'h01, 8'h02);
    take_rsp("R11", 8'hFF, 8'h00, 8'hFF, 1'b0);
    send(8'h22, 8'h03, 8'h04);
    take_rsp("R11", 8'hFF, 8'h00, 8'hFF, 1'b0);
    send(8'h23, 8'h80, 8'h00);
    take_wr("R11", 16'h8000, 8'h5A, 1'b1, 1'b1);
    take_wr("R11", 16'h8001, 8'hA5, 1'b1, 1'b1);
    send(8'h10, 8'h42, 8'hBD);
    take_rsp("R2", 8'hA0, 8'h42, 8'hBD, 1'b0);
    send(8'h23, 8'h90, 8'h00);
    take_rsp("R11", 8'hFF, 8'h00, 8'hFF, 1'b0);
    send(8'h22, 8'h90, 8'h01);
    take_wr("R11", 16'h9001, 8'h42, 1'b1, 1'b0);
    idle_chk("R11");

    // R10: each destination with nothing staged
    for (int j = 0; j < 4; j++) begin
      send(8'(8'h20 + j), 8'h33, 8'h33);
      take_rsp("R10", 8'hFF, 8'h00, 8'hFF, 1'b0);
    end

    // R12: every identifier outside the command set
    for (int id = 0; id < 256; id++) begin
      if (id != 8'h10 && id != 8'h11 && (id < 8'h20 || id > 8'h23)) begin
        send(id[7:0], 8'h12, 8'hED);
        take_rsp("R12", 8'hFF, 8'h00, 8'hFF, 1'b0);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule